// File: doc/BRIEF.md
# Dual DAC Serial Command Interface

This block is the digital control front end of a two-channel 14-bit DAC. A host shifts a serial word in on the serial clock while an active-low select/load strobe is held low. When the strobe goes high again, the block decodes the most recently received 24 bits and acts on them. The upper 8 of those bits carry an operation nibble and a target nibble, and the lower 16 carry the data. The operations are: load a new code into a channel and update it, select fast or slow settling, and power a channel down.

The register that receives the serial bits is 32 bits deep, and its top stage drives a serial output. A host can therefore send either a plain 24-bit frame or a 32-bit frame whose first byte is filler. Several devices can also be chained output-to-input and updated together by one shared strobe. All inputs are sampled on the block's system clock, so the serial clock and the strobe act through their sampled edges. An active-low asynchronous clear empties both the receive register and the code latches. A separate reset returns the whole block to its power-on defaults.

Top module: `dac_cmd_if`

## Requirements
- R1: While `cs_n_i` is low, each sampled rising edge of `sck_i` shifts `sdi_i` into the receive register, most significant bit first. `sdo_o` always shows the register's top stage, which is the bit received 32 shifts earlier. Before 32 bits have been received it shows 0.
- R2: While `cs_n_i` is high, `sck_i` edges shift nothing, so `sdo_o` and all channel outputs stay unchanged.
- R3: The command is taken from the 24 most recently received bits. In a 32-bit frame, the first 8 bits have no effect on any channel output.
- R4: Within the command, bits 23:20 are the operation and bits 19:16 are the target. Operation 0011 loads command bits 15:2 into the target channel's code output. Bits 1:0 are ignored.
- R5: Target 0000 selects channel A, 0001 selects channel B, and 1111 selects both channels.
- R6: Operation 0101 sets the target's fast output to 1 (fast settling). Operation 0110 clears it to 0 (slow settling).
- R7: Operation 0100 sets the target's powerdown output to 1. A load (0011) on a channel clears that channel's powerdown output.
- R8: Any other operation code, or any other target code, leaves every code, fast and powerdown output unchanged.
- R9: Reset (`rst_n` low) gives zero codes, slow mode (fast = 0), no powerdown, and a zero receive register (`sdo_o` = 0).
- R10: While `clr_n` is low, both codes and the receive register are zero at once, without waiting for a clock edge. Fast and powerdown outputs keep their values. A strobe rise that coincides with the clear has no effect.
- R11: Channel outputs change only in the clock cycle that follows a sampled rising edge of `cs_n_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset to power-on defaults |
| clr_n | input | 1 | Asynchronous active-low clear of the receive register and code latches |
| sck_i | input | 1 | Serial shift clock |
| cs_n_i | input | 1 | Active-low select; its rising edge executes the command |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Top stage of the receive register, for daisy-chaining |
| code_a_o | output | 14 | Channel A code latch |
| code_b_o | output | 14 | Channel B code latch |
| fast_a_o | output | 1 | Channel A settling mode (1 = fast) |
| fast_b_o | output | 1 | Channel B settling mode (1 = fast) |
| pd_a_o | output | 1 | Channel A powered down |
| pd_b_o | output | 1 | Channel B powered down |

## Verification
A corrupted receive register shows up on `sdo_o` one shift after the bad stage reaches the top. It also shows up on the channel outputs in the cycle after the next strobe rise, because the wrong command is then decoded. A fault in the per-channel state shows up on that channel's code, fast or powerdown output one cycle after the strobe rise that should have changed it, or should have left it alone. The bench sends all 256 control bytes, each with varied data, and predicts all six channel outputs arithmetically after every frame. It also follows `sdo_o` bit by bit against a model of the 32-bit register.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;
    localparam int NCH = 2;
    localparam int NIB_W = 4;

    typedef enum logic [NIB_W-1:0] {
        OP_LOAD = 4'b0011,
        OP_PDN  = 4'b0100,
        OP_FAST = 4'b0101,
        OP_SLOW = 4'b0110
    } op_e;

    localparam logic [NIB_W-1:0] TGT_ALL = 4'b1111;

    // one-hot-per-channel strobes produced by the decoder
    typedef struct packed {
        logic [NCH-1:0] ld;
        logic [NCH-1:0] pdn;
        logic [NCH-1:0] fast;
        logic [NCH-1:0] slow;
    } chan_cmd_t;
endpackage

// File: rtl/dac_cmd_shift.sv
module dac_cmd_shift #(
    parameter int SR_W   = 32,
    parameter int CMD_W  = 24,
    parameter int DROP_W = 2
) (
    input  logic                    clk,
    input  logic                    arst_n,
    input  logic                    sck_i,
    input  logic                    cs_n_i,
    input  logic                    sdi_i,
    output logic                    sdo_o,
    output logic [CMD_W-1:DROP_W]   cmd_o,
    output logic                    exec_o
);
    typedef struct packed {
        logic [SR_W-1:0] sr;
        logic            sck;
        logic            cs_n;
    } shift_st_t;

    // sampled edges idle high so nothing fires when reset or clear ends
    localparam shift_st_t RST_ST = '{sr: '0, sck: 1'b1, cs_n: 1'b1};

    shift_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sck  = sck_i;
        st_d.cs_n = cs_n_i;
        if (!cs_n_i && sck_i && !st_q.sck) begin
            st_d.sr = {st_q.sr[SR_W-2:0], sdi_i};
        end
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) st_q <= RST_ST;
        else         st_q <= st_d;
    end

    assign sdo_o  = st_q.sr[SR_W-1];
    assign cmd_o  = st_q.sr[CMD_W-1:DROP_W];
    assign exec_o = cs_n_i && !st_q.cs_n;
endmodule

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
    import dac_cmd_pkg::*;
#(
    parameter int CMD_W  = 24,
    parameter int DATA_W = 16,
    parameter int CODE_W = 14,
    localparam int DROP_W = DATA_W - CODE_W
) (
    input  logic                  exec_i,
    input  logic [CMD_W-1:DROP_W] cmd_i,
    output chan_cmd_t             ccmd_o,
    output logic [CODE_W-1:0]     code_o
);
    logic [NIB_W-1:0] op_w;
    logic [NIB_W-1:0] tgt_w;
    logic [NCH-1:0]   hit_w;

    assign op_w   = cmd_i[CMD_W-1 -: NIB_W];
    assign tgt_w  = cmd_i[CMD_W-1-NIB_W -: NIB_W];
    assign code_o = cmd_i[DATA_W-1:DROP_W];

    for (genvar c = 0; c < NCH; c++) begin : g_hit
        assign hit_w[c] = exec_i && ((tgt_w == NIB_W'(c)) || (tgt_w == TGT_ALL));
    end

    always_comb begin
        ccmd_o = '0;
        case (op_w)
            OP_LOAD: ccmd_o.ld   = hit_w;
            OP_PDN:  ccmd_o.pdn  = hit_w;
            OP_FAST: ccmd_o.fast = hit_w;
            OP_SLOW: ccmd_o.slow = hit_w;
            default: ccmd_o      = '0;
        endcase
    end
endmodule

// File: rtl/dac_chan_reg.sv
module dac_chan_reg #(
    parameter int CODE_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lat_rst_n,
    input  logic              ld_i,
    input  logic              pdn_i,
    input  logic              fast_i,
    input  logic              slow_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [CODE_W-1:0] code_o,
    output logic              fast_o,
    output logic              pd_o
);
    typedef struct packed {
        logic [CODE_W-1:0] code;
    } lat_t;

    typedef struct packed {
        logic fast;
        logic pd;
    } cfg_t;

    lat_t lat_d, lat_q;
    cfg_t cfg_d, cfg_q;

    always_comb begin
        lat_d = lat_q;
        cfg_d = cfg_q;
        if (ld_i) begin
            lat_d.code = code_i;
            cfg_d.pd   = 1'b0;
        end
        if (pdn_i)  cfg_d.pd   = 1'b1;
        if (fast_i) cfg_d.fast = 1'b1;
        if (slow_i) cfg_d.fast = 1'b0;
    end

    // code latch: cleared by reset or clear
    always_ff @(posedge clk or negedge lat_rst_n) begin
        if (!lat_rst_n) lat_q <= '0;
        else            lat_q <= lat_d;
    end

    // mode and powerdown: reset only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign code_o = lat_q.code;
    assign fast_o = cfg_q.fast;
    assign pd_o   = cfg_q.pd;
endmodule

// File: rtl/dac_cmd_if.sv
module dac_cmd_if
    import dac_cmd_pkg::*;
#(
    parameter int CODE_W = 14,
    parameter int DATA_W = 16,
    parameter int CTRL_W = 8,
    parameter int SR_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic              sck_i,
    input  logic              cs_n_i,
    input  logic              sdi_i,
    output logic              sdo_o,
    output logic [CODE_W-1:0] code_a_o,
    output logic [CODE_W-1:0] code_b_o,
    output logic              fast_a_o,
    output logic              fast_b_o,
    output logic              pd_a_o,
    output logic              pd_b_o
);
    localparam int CMD_W  = CTRL_W + DATA_W;
    localparam int DROP_W = DATA_W - CODE_W;

    logic                  arst_n;
    logic                  exec_w;
    logic [CMD_W-1:DROP_W] cmd_w;
    chan_cmd_t             ccmd_w;
    logic [CODE_W-1:0]     new_code_w;
    logic [CODE_W-1:0]     code_w [NCH];
    logic [NCH-1:0]        fast_w;
    logic [NCH-1:0]        pd_w;

    assign arst_n = rst_n & clr_n;

    dac_cmd_shift #(
        .SR_W   (SR_W),
        .CMD_W  (CMD_W),
        .DROP_W (DROP_W)
    ) u_shift (
        .clk    (clk),
        .arst_n (arst_n),
        .sck_i  (sck_i),
        .cs_n_i (cs_n_i),
        .sdi_i  (sdi_i),
        .sdo_o  (sdo_o),
        .cmd_o  (cmd_w),
        .exec_o (exec_w)
    );

    dac_cmd_decode #(
        .CMD_W  (CMD_W),
        .DATA_W (DATA_W),
        .CODE_W (CODE_W)
    ) u_dec (
        .exec_i (exec_w),
        .cmd_i  (cmd_w),
        .ccmd_o (ccmd_w),
        .code_o (new_code_w)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        dac_chan_reg #(.CODE_W(CODE_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .lat_rst_n (arst_n),
            .ld_i      (ccmd_w.ld[c]),
            .pdn_i     (ccmd_w.pdn[c]),
            .fast_i    (ccmd_w.fast[c]),
            .slow_i    (ccmd_w.slow[c]),
            .code_i    (new_code_w),
            .code_o    (code_w[c]),
            .fast_o    (fast_w[c]),
            .pd_o      (pd_w[c])
        );
    end

    assign code_a_o = code_w[0];
    assign code_b_o = code_w[1];
    assign fast_a_o = fast_w[0];
    assign fast_b_o = fast_w[1];
    assign pd_a_o   = pd_w[0];
    assign pd_b_o   = pd_w[1];
endmodule

// File: rtl/dac_cmd_if_chk.sv
module dac_cmd_if_chk #(
    parameter int CODE_W = 14,
    parameter int DATA_W = 16,
    parameter int CTRL_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr_n,
    input logic              sck_i,
    input logic              cs_n_i,
    input logic              sdi_i,
    input logic              sdo_o,
    input logic [CODE_W-1:0] code_a_o,
    input logic [CODE_W-1:0] code_b_o,
    input logic              fast_a_o,
    input logic              fast_b_o,
    input logic              pd_a_o,
    input logic              pd_b_o
);
    localparam int CMD_W = CTRL_W + DATA_W;

    logic             sck_q, cs_q;
    logic [CMD_W-1:0] sh_q;
    logic             shift_ev, exec_ev;
    logic [3:0]       op_w, tgt_w;

    always_ff @(posedge clk or negedge rst_n or negedge clr_n) begin
        if (!rst_n || !clr_n) begin
            sck_q <= 1'b1;
            cs_q  <= 1'b1;
            sh_q  <= '0;
        end else begin
            sck_q <= sck_i;
            cs_q  <= cs_n_i;
            if (shift_ev) sh_q <= {sh_q[CMD_W-2:0], sdi_i};
        end
    end

    assign shift_ev = !cs_n_i && sck_i && !sck_q;
    assign exec_ev  = cs_n_i && !cs_q;
    assign op_w     = sh_q[CMD_W-1 -: 4];
    assign tgt_w    = sh_q[CMD_W-5 -: 4];

    // R1: the serial output only moves on a shift
    a_r1_sdo_on_shift: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        !shift_ev |=> $stable(sdo_o));

    // R11 (and R2, R8 when no strobe rise): outputs move only after a strobe rise
    a_r11_hold_between: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        !exec_ev |=> ($stable(code_a_o) && $stable(code_b_o) && $stable(fast_a_o)
                      && $stable(fast_b_o) && $stable(pd_a_o) && $stable(pd_b_o)));

    // R4 with R7: a load on channel A takes the data field and wakes the channel
    a_r4_load_a: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        (exec_ev && op_w == 4'b0011 && (tgt_w == 4'b0000 || tgt_w == 4'b1111))
        |=> (code_a_o == $past(sh_q[DATA_W-1 -: CODE_W]) && !pd_a_o));

    // R6: fast on channel B
    a_r6_fast_b: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
        (exec_ev && op_w == 4'b0101 && (tgt_w == 4'b0001 || tgt_w == 4'b1111))
        |=> fast_b_o);

    // R10: clear holds codes and the serial output at zero
    a_r10_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> (code_a_o == '0 && code_b_o == '0 && !sdo_o));

    // R9: reset values
    always @(posedge clk) begin
        if (!rst_n) begin
            a_r9_reset_vals: assert (code_a_o == '0 && code_b_o == '0 && !fast_a_o
                && !fast_b_o && !pd_a_o && !pd_b_o && !sdo_o);
        end
    end
endmodule

bind dac_cmd_if dac_cmd_if_chk #(
    .CODE_W (CODE_W),
    .DATA_W (DATA_W),
    .CTRL_W (CTRL_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_n    (clr_n),
    .sck_i    (sck_i),
    .cs_n_i   (cs_n_i),
    .sdi_i    (sdi_i),
    .sdo_o    (sdo_o),
    .code_a_o (code_a_o),
    .code_b_o (code_b_o),
    .fast_a_o (fast_a_o),
    .fast_b_o (fast_b_o),
    .pd_a_o   (pd_a_o),
    .pd_b_o   (pd_b_o)
);

// File: tb/sim_dac_cmd_if.sv
module sim_dac_cmd_if;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr_n = 1'b1;
    logic        sck = 1'b0;
    logic        cs_n = 1'b1;
    logic        sdi = 1'b0;
    logic        sdo;
    logic [13:0] code_a, code_b;
    logic        fast_a, fast_b, pd_a, pd_b;

    int n_chk = 0;
    int n_err = 0;

    logic [31:0] m_sr = '0;
    logic [13:0] m_code [2];
    bit          m_fast [2];
    bit          m_pd   [2];

    always #4 clk = ~clk;

    dac_cmd_if u0 (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .sck_i(sck), .cs_n_i(cs_n),
        .sdi_i(sdi), .sdo_o(sdo), .code_a_o(code_a), .code_b_o(code_b),
        .fast_a_o(fast_a), .fast_b_o(fast_b), .pd_a_o(pd_a), .pd_b_o(pd_b)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic chk_outs(input string tag);
        chk(code_a == m_code[0], tag, "code_a", int'(code_a), int'(m_code[0]));
        chk(code_b == m_code[1], tag, "code_b", int'(code_b), int'(m_code[1]));
        chk(fast_a == m_fast[0], tag, "fast_a", int'(fast_a), int'(m_fast[0]));
        chk(fast_b == m_fast[1], tag, "fast_b", int'(fast_b), int'(m_fast[1]));
        chk(pd_a == m_pd[0], tag, "pd_a", int'(pd_a), int'(m_pd[0]));
        chk(pd_b == m_pd[1], tag, "pd_b", int'(pd_b), int'(m_pd[1]));
    endtask

    // model of a command taken from the low 24 received bits
    task automatic model_exec(input logic [23:0] cmd);
        logic [3:0] op  = cmd[23:20];
        logic [3:0] tgt = cmd[19:16];
        for (int c = 0; c < 2; c++) begin
            if (tgt == 4'(c) || tgt == 4'hF) begin
                case (op)
                    4'b0011: begin m_code[c] = cmd[15:2]; m_pd[c] = 1'b0; end
                    4'b0100: m_pd[c] = 1'b1;
                    4'b0101: m_fast[c] = 1'b1;
                    4'b0110: m_fast[c] = 1'b0;
                    default: ;
                endcase
            end
        end
    endtask

    task automatic shift_bit(input bit b);
        @(negedge clk); sdi = b; sck = 1'b0;
        repeat (2) @(negedge clk);
        sck = 1'b1;
        repeat (2) @(negedge clk);
        if (!cs_n) m_sr = {m_sr[30:0], b};
        chk(sdo == m_sr[31], "R1", "sdo", int'(sdo), int'(m_sr[31]));
    endtask

    task automatic send(input logic [31:0] w, input int nbits, input string tag);
        @(negedge clk); sck = 1'b0; cs_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = nbits - 1; i >= 0; i--) shift_bit(w[i]);
        @(negedge clk); sck = 1'b0;
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        model_exec(m_sr[23:0]);
        repeat (4) @(negedge clk);
        chk_outs(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        for (int c = 0; c < 2; c++) begin
            m_code[c] = '0; m_fast[c] = 1'b0; m_pd[c] = 1'b0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R9 reset state
        chk_outs("R9");
        chk(sdo == 1'b0, "R9", "sdo", int'(sdo), 0);

        // R4: load A, low two data bits ignored
        send({8'h00, 8'h30, 16'hABCF}, 24, "R4");
        // R5: load B, then both
        send({8'h00, 8'h31, 16'h1234}, 24, "R5");
        send({8'h00, 8'h3F, 16'h5557}, 24, "R5");
        // R6: fast then slow on A
        send({8'h00, 8'h50, 16'h0000}, 24, "R6");
        send({8'h00, 8'h60, 16'hFFFF}, 24, "R6");
        // R7: power both down, then a load on A wakes only A
        send({8'h00, 8'h4F, 16'h0000}, 24, "R7");
        send({8'h00, 8'h30, 16'h0F0C}, 24, "R7");
        // R3: 32-bit frame, filler byte looks like a load to both
        send({8'h3F, 8'h51, 16'hFFFF}, 32, "R3");
        // R8: bad target with a valid op
        send({8'h00, 8'h32, 16'h7777}, 24, "R8");

        // R2: serial clock with strobe high shifts nothing
        cs_n = 1'b1;
        for (int k = 0; k < 6; k++) shift_bit(1'b1);
        @(negedge clk); sck = 1'b0;
        repeat (3) @(negedge clk);
        chk_outs("R2");

        // R8 sweep of every control byte with varied data
        for (int c = 0; c < 256; c++) begin
            send({8'h00, 8'(c), 16'((c * 40503 + 12345) & 16'hFFFF)}, 24, "R8 sweep");
        end

        // R10: asynchronous clear in mid-frame
        send({8'h00, 8'h3F, 16'hFFFF}, 24, "R10 setup");
        send({8'h00, 8'h50, 16'h0000}, 24, "R10 setup");
        send({8'h00, 8'h41, 16'h0000}, 24, "R10 setup");
        @(negedge clk); sck = 1'b0; cs_n = 1'b0;
        for (int k = 0; k < 10; k++) shift_bit(1'b1);
        @(negedge clk); clr_n = 1'b0;
        #1;
        m_sr = '0; m_code[0] = '0; m_code[1] = '0;
        chk_outs("R10");
        chk(sdo == 1'b0, "R10", "sdo", int'(sdo), 0);
        repeat (3) @(negedge clk);
        sck = 1'b0; clr_n = 1'b1;
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        model_exec(m_sr[23:0]);
        repeat (4) @(negedge clk);
        chk_outs("R10");

        // R10: clear coinciding with the strobe rise wins
        send({8'h00, 8'h31, 16'h4444}, 24, "R10 setup");
        @(negedge clk); sck = 1'b0; cs_n = 1'b0;
        for (int k = 23; k >= 0; k--) shift_bit(k == 22 || k == 20 || k == 16);
        @(negedge clk); sck = 1'b0;
        repeat (2) @(negedge clk);
        cs_n = 1'b1; clr_n = 1'b0;
        m_sr = '0; m_code[0] = '0; m_code[1] = '0;
        repeat (3) @(negedge clk);
        clr_n = 1'b1;
        repeat (4) @(negedge clk);
        chk_outs("R10 clear wins");
        chk(sdo == 1'b0, "R10", "sdo", int'(sdo), 0);

        // R11: outputs stay put while a frame shifts in
        @(negedge clk); cs_n = 1'b0;
        for (int k = 0; k < 24; k++) begin
            shift_bit(1'b1);
            if (k % 8 == 7) chk_outs("R11");
        end
        @(negedge clk); sck = 1'b0;
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        model_exec(m_sr[23:0]);
        repeat (4) @(negedge clk);
        chk_outs("R11");

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule